// File: doc/BRIEF.md
# GPIO controller with interrupt modes

This block is a register-mapped general-purpose I/O controller for a parameterised number of pins (8 or 12). Software reaches it over a plain 32-bit register bus: an 8-bit byte address, a write strobe, write data, and read data that follows the address in the same cycle. Each pin has a direction bit and an output latch. Each pin's input is brought into the clock domain through two flops.

Every pin has its own interrupt detector. A 3-bit mode field selects one of five conditions: rising edge, falling edge, either edge, high level or low level. A detected condition sets a sticky status bit, but only while that pin's enable bit is set. Software clears status by writing ones. A mask register has one port that sets bits and one that clears them. The masked view of status is ORed and registered to drive a single interrupt line. A two-step write to a soft-reset register returns every configuration and status register to its reset value.

Top module: `gpioirq_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq_out` is 0, except the mask register at 0x10, which reads all ones over the pin range.
- R2: `pin_oe` equals the direction register (0x20) and `pin_out` equals the output-data register (0x18), from the cycle after the write.
- R3: The input register (0x1C) shows a level change on `pin_in` on the second clock edge after the change.
- R4: Pin p < 8 has its mode in bits [4p+2:4p] of the word at 0x24. Pin p >= 8 has its mode in bits [4(p-8)+2:4(p-8)] of the word at 0x28. Bit 4k+3 of each nibble, and the nibbles of absent pins, read zero. The encodings are: 0 = falling edge, 1 = rising edge, 2 = low level, 3 = high level, 4 = either edge, 5 to 7 = no detection.
- R5: An edge mode sets the status bit (0x04) on the qualifying edge of the synchronised input, but only while the enable bit (0x00) is 1. The bit stays set after the input returns.
- R6: In a level mode, the status bit is set again on every cycle that the level is active and the pin is enabled. Writing a clear therefore has no lasting effect while the level persists.
- R7: Writing a 1 to a bit of 0x0C clears that status bit. If a new event on the same pin falls in the same cycle, the status bit stays set.
- R8: Writing ones to 0x10 sets mask bits and writing ones to 0x14 clears them. Zero bits leave the mask unchanged. The mask reads back at 0x10.
- R9: The view register (0x08) reads status AND enable AND NOT mask. `irq_out` is the OR of the view, one cycle later.
- R10: Writing 1 to bit 0 of 0x3C and then writing 0 resets every register. Writing the 1 alone changes nothing else.
- R11: Register bits at or above the pin count read zero, and writes to them are ignored. This includes the spare-select register at 0x38.
- R12: Reserved offsets 0x2C, 0x30 and 0x34 read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | NPIN | Pin levels |
| pin_out | output | NPIN | Output-data drive |
| pin_oe | output | NPIN | Output enable per pin |
| irq_out | output | 1 | Combined interrupt |

## Verification
The status register takes a software clear and a hardware set in one update, and the two can fall on the same pin in the same cycle. The bench provokes this by raising an either-edge pin exactly two clock edges before the clear write lands. At that point the detector fires in the cycle the clear is applied. The bench then expects the status bit to read back as still set, and a second clear with a quiet pin to remove it. A level pin that is still active is judged the same way, since its status must survive a clear.

// File: rtl/gpioirq_pkg.sv
package gpioirq_pkg;
    localparam int BUS_AW        = 8;
    localparam int BUS_DW        = 32;
    localparam int PINS_PER_WORD = 8;
    localparam int MODE_W        = 3;
    localparam int MODE_SLOTS    = 2 * PINS_PER_WORD;

    localparam logic [BUS_AW-1:0] OFF_IRQ_EN   = 8'h00;
    localparam logic [BUS_AW-1:0] OFF_IRQ_STAT = 8'h04;
    localparam logic [BUS_AW-1:0] OFF_IRQ_VIEW = 8'h08;
    localparam logic [BUS_AW-1:0] OFF_IRQ_ACK  = 8'h0C;
    localparam logic [BUS_AW-1:0] OFF_MASK_SET = 8'h10;
    localparam logic [BUS_AW-1:0] OFF_MASK_CLR = 8'h14;
    localparam logic [BUS_AW-1:0] OFF_DOUT     = 8'h18;
    localparam logic [BUS_AW-1:0] OFF_DIN      = 8'h1C;
    localparam logic [BUS_AW-1:0] OFF_DIR      = 8'h20;
    localparam logic [BUS_AW-1:0] OFF_MODE_LO  = 8'h24;
    localparam logic [BUS_AW-1:0] OFF_MODE_HI  = 8'h28;
    localparam logic [BUS_AW-1:0] OFF_ALT_SEL  = 8'h38;
    localparam logic [BUS_AW-1:0] OFF_SOFT_RST = 8'h3C;

    typedef enum logic [MODE_W-1:0] {
        MODE_FALL = 3'd0,
        MODE_RISE = 3'd1,
        MODE_LOW  = 3'd2,
        MODE_HIGH = 3'd3,
        MODE_BOTH = 3'd4
    } irq_mode_e;
endpackage

// File: rtl/gpioirq_pin_sense.sv
module gpioirq_pin_sense
    import gpioirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              sync_o,
    output logic              evt_o
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sense_t;

    sense_t sense_d, sense_q;

    always_comb begin
        sense_d      = sense_q;
        sense_d.meta = pin_i;
        sense_d.sync = sense_q.meta;
        sense_d.prev = sense_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sense_q <= '0;
        else        sense_q <= sense_d;
    end

    // Detection compares the synchronised level with its previous sample.
    always_comb begin
        case (irq_mode_e'(mode_i))
            MODE_FALL: evt_o = !sense_q.sync &&  sense_q.prev;
            MODE_RISE: evt_o =  sense_q.sync && !sense_q.prev;
            MODE_LOW:  evt_o = !sense_q.sync;
            MODE_HIGH: evt_o =  sense_q.sync;
            MODE_BOTH: evt_o =  sense_q.sync ^ sense_q.prev;
            default:   evt_o = 1'b0;
        endcase
    end

    assign sync_o = sense_q.sync;
endmodule

// File: rtl/gpioirq_regs.sv
module gpioirq_regs
    import gpioirq_pkg::*;
#(
    parameter int NPIN = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [BUS_AW-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [BUS_DW-1:0]           bus_wdata,
    output logic [BUS_DW-1:0]           bus_rdata,
    input  logic [NPIN-1:0]             pin_sync_i,
    input  logic [NPIN-1:0]             pin_evt_i,
    output logic [NPIN-1:0][MODE_W-1:0] mode_o,
    output logic [NPIN-1:0]             dir_o,
    output logic [NPIN-1:0]             dout_o,
    output logic                        irq_o
);
    localparam int NIB = 4;

    typedef struct packed {
        logic [NPIN-1:0]                   en;
        logic [NPIN-1:0]                   stat;
        logic [NPIN-1:0]                   mask;
        logic [NPIN-1:0]                   dout;
        logic [NPIN-1:0]                   dir;
        logic [NPIN-1:0]                   alt;
        logic [MODE_SLOTS-1:0][MODE_W-1:0] mode;
        logic                              srst;
        logic                              irq;
    } regs_t;

    function automatic regs_t reset_value();
        regs_t r;
        r      = '0;
        r.mask = '1;
        return r;
    endfunction

    regs_t           d, q;
    logic [NPIN-1:0] view;
    logic [NPIN-1:0] wr_bits;
    logic [NPIN-1:0] ack;
    logic [NPIN-1:0] live_evt;
    logic            srst_fire;
    logic            unused_wdata;

    assign view         = q.stat & q.en & ~q.mask;
    assign wr_bits      = bus_wdata[NPIN-1:0];
    assign live_evt     = pin_evt_i & q.en;
    assign srst_fire    = bus_we && (bus_addr == OFF_SOFT_RST) && !bus_wdata[0] && q.srst;
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        d   = q;
        ack = '0;
        if (bus_we) begin
            case (bus_addr)
                OFF_IRQ_EN:   d.en   = wr_bits;
                OFF_IRQ_ACK:  ack    = wr_bits;
                OFF_MASK_SET: d.mask = q.mask | wr_bits;
                OFF_MASK_CLR: d.mask = q.mask & ~wr_bits;
                OFF_DOUT:     d.dout = wr_bits;
                OFF_DIR:      d.dir  = wr_bits;
                OFF_ALT_SEL:  d.alt  = wr_bits;
                OFF_SOFT_RST: d.srst = bus_wdata[0];
                OFF_MODE_LO: begin
                    for (int s = 0; s < PINS_PER_WORD; s++)
                        d.mode[s] = bus_wdata[NIB*s +: MODE_W];
                end
                OFF_MODE_HI: begin
                    for (int s = 0; s < PINS_PER_WORD; s++)
                        d.mode[PINS_PER_WORD + s] = bus_wdata[NIB*s +: MODE_W];
                end
                default: ;
            endcase
        end
        for (int s = 0; s < MODE_SLOTS; s++) begin
            if (s >= NPIN) d.mode[s] = '0;
        end
        // A hardware event in the same cycle wins over the software clear.
        d.stat = (q.stat & ~ack) | live_evt;
        d.irq  = |view;
        if (srst_fire) begin
            d     = reset_value();
            d.irq = |view;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= reset_value();
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_IRQ_EN:   bus_rdata[NPIN-1:0] = q.en;
            OFF_IRQ_STAT: bus_rdata[NPIN-1:0] = q.stat;
            OFF_IRQ_VIEW: bus_rdata[NPIN-1:0] = view;
            OFF_MASK_SET: bus_rdata[NPIN-1:0] = q.mask;
            OFF_DOUT:     bus_rdata[NPIN-1:0] = q.dout;
            OFF_DIN:      bus_rdata[NPIN-1:0] = pin_sync_i;
            OFF_DIR:      bus_rdata[NPIN-1:0] = q.dir;
            OFF_ALT_SEL:  bus_rdata[NPIN-1:0] = q.alt;
            OFF_SOFT_RST: bus_rdata[0]        = q.srst;
            OFF_MODE_LO: begin
                for (int s = 0; s < PINS_PER_WORD; s++)
                    bus_rdata[NIB*s +: MODE_W] = q.mode[s];
            end
            OFF_MODE_HI: begin
                for (int s = 0; s < PINS_PER_WORD; s++)
                    bus_rdata[NIB*s +: MODE_W] = q.mode[PINS_PER_WORD + s];
            end
            default: ;
        endcase
    end

    assign mode_o = q.mode[NPIN-1:0];
    assign dir_o  = q.dir;
    assign dout_o = q.dout;
    assign irq_o  = q.irq;

    p_dir_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_DIR) |=> (dir_o == $past(bus_wdata[NPIN-1:0])))
        else $error("direction not taken from write");

    p_enable_gates_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q.stat & ~$past(q.stat) & ~$past(q.en)) == '0))
        else $error("status set on a disabled pin");

    p_event_sets_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !srst_fire |=> ((q.stat & $past(live_evt)) == $past(live_evt)))
        else $error("enabled event did not set status");

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_IRQ_ACK)
            |=> ((q.stat & $past(bus_wdata[NPIN-1:0] & ~live_evt)) == '0))
        else $error("status survived a clear without an event");

    p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_MASK_SET)
            |=> ((q.mask & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])))
        else $error("mask set port failed");

    p_mask_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_MASK_CLR)
            |=> ((q.mask & $past(bus_wdata[NPIN-1:0])) == '0))
        else $error("mask clear port failed");

    p_irq_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|view) |=> irq_o)
        else $error("irq missed a visible status");

    p_irq_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|view) |=> !irq_o)
        else $error("irq raised with empty view");

    p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        srst_fire |=> (q.en == '0 && q.stat == '0 && q.mask == '1 && q.dir == '0))
        else $error("soft reset left state behind");
endmodule

// File: rtl/gpioirq_ctrl.sv
module gpioirq_ctrl
    import gpioirq_pkg::*;
#(
    parameter int NPIN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq_out
);
    logic [NPIN-1:0]             pin_sync;
    logic [NPIN-1:0]             pin_evt;
    logic [NPIN-1:0][MODE_W-1:0] pin_mode;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        gpioirq_pin_sense u_sense (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_in[i]),
            .mode_i (pin_mode[i]),
            .sync_o (pin_sync[i]),
            .evt_o  (pin_evt[i])
        );
    end

    gpioirq_regs #(.NPIN(NPIN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_sync_i (pin_sync),
        .pin_evt_i  (pin_evt),
        .mode_o     (pin_mode),
        .dir_o      (pin_oe),
        .dout_o     (pin_out),
        .irq_o      (irq_out)
    );
endmodule

// File: tb/gpioirq_ctrl_tb_top.sv
module gpioirq_ctrl_tb_top;
    import gpioirq_pkg::*;
    localparam int NPIN = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [BUS_AW-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [BUS_DW-1:0] bus_wdata = '0;
    logic [BUS_DW-1:0] bus_rdata;
    logic [NPIN-1:0]   pin_in = '0;
    logic [NPIN-1:0]   pin_out;
    logic [NPIN-1:0]   pin_oe;
    logic              irq_out;

    int checks = 0;
    int fails  = 0;
    logic mon_req = 1'b0;
    logic done = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #5 clk = ~clk;

    gpioirq_ctrl #(.NPIN(NPIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // Monitor: pops one expected item per requested sample.
    always @(negedge clk) begin
        if (mon_req && sbq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            case (it.kind)
                1:       act = {31'd0, irq_out};
                2:       act = 32'(pin_oe);
                3:       act = 32'(pin_out);
                default: act = bus_rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(posedge clk);
        #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = v;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic chk(input int kind, input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a; bus_we = 1'b0;
        it.kind = kind; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        mon_req = 1'b1;
        @(posedge clk);
        #1;
        mon_req = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        chk(0, a, e, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R1 actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd(OFF_IRQ_EN,   32'h0,   "R1 enable");
        rd(OFF_IRQ_STAT, 32'h0,   "R1 status");
        rd(OFF_MASK_SET, 32'hFFF, "R1 mask");
        rd(OFF_DOUT,     32'h0,   "R1 dout");
        rd(OFF_MODE_LO,  32'h0,   "R1 mode");
        chk(2, 8'h0, 32'h0,       "R1 oe");
        chk(1, 8'h0, 32'h0,       "R1 irq");
        // R11 and R2
        wr(OFF_DOUT, 32'hFFFF_FFFF);
        rd(OFF_DOUT, 32'hFFF, "R11 dout upper bits");
        wr(OFF_DIR, 32'h0A5);
        chk(2, 8'h0, 32'h0A5, "R2 oe");
        chk(3, 8'h0, 32'hFFF, "R2 out");
        wr(OFF_DOUT, 32'h0F0);
        chk(3, 8'h0, 32'h0F0, "R2 out update");
        wr(OFF_ALT_SEL, 32'hFFFF_F003);
        rd(OFF_ALT_SEL, 32'h003, "R11 spare select");
        // R12 reserved
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h2C, 32'h0, "R12 reserved 2C");
        rd(8'h30, 32'h0, "R12 reserved 30");
        rd(8'h34, 32'h0, "R12 reserved 34");
        rd(OFF_IRQ_EN, 32'h0, "R12 no side effect");
        // R3 synchroniser latency
        pin_in = 12'h5A3;
        rd(OFF_DIN, 32'h0,   "R3 edge 1");
        rd(OFF_DIN, 32'h0,   "R3 edge 2 pending");
        rd(OFF_DIN, 32'h5A3, "R3 value");
        pin_in = 12'h010;
        tick(3);
        // R4 mode fields
        wr(OFF_MODE_LO, 32'hFFFF_FFFF);
        rd(OFF_MODE_LO, 32'h7777_7777, "R4 word0 spare bits");
        wr(OFF_MODE_HI, 32'hFFFF_FFFF);
        rd(OFF_MODE_HI, 32'h0000_7777, "R4 word1 absent pins");
        wr(OFF_MODE_LO, 32'h7772_3401);
        rd(OFF_MODE_LO, 32'h7772_3401, "R4 word0 layout");
        wr(OFF_MODE_HI, 32'hFFFF_7717);
        rd(OFF_MODE_HI, 32'h0000_7717, "R4 word1 layout");
        // R5 enable gating, rising edge on pin0
        pin_in = 12'h011;
        tick(4);
        rd(OFF_IRQ_STAT, 32'h0, "R5 disabled edge");
        wr(OFF_IRQ_EN, 32'h21F);
        rd(OFF_IRQ_STAT, 32'h0, "R5 enable alone");
        pin_in = 12'h010;
        tick(4);
        rd(OFF_IRQ_STAT, 32'h0, "R5 falling on rising mode");
        pin_in = 12'h011;
        tick(3);
        rd(OFF_IRQ_STAT, 32'h001, "R5 rising sets");
        pin_in = 12'h010;
        tick(3);
        rd(OFF_IRQ_STAT, 32'h001, "R5 sticky");
        // R9 and R8
        rd(OFF_IRQ_VIEW, 32'h0, "R9 masked view");
        chk(1, 8'h0, 32'h0, "R9 irq masked");
        wr(OFF_MASK_CLR, 32'h001);
        chk(1, 8'h0, 32'h0, "R9 irq latency");
        chk(1, 8'h0, 32'h1, "R9 irq raised");
        rd(OFF_MASK_SET, 32'hFFE, "R8 mask clear");
        rd(OFF_IRQ_VIEW, 32'h001, "R9 view");
        wr(OFF_MASK_SET, 32'h0);
        rd(OFF_MASK_SET, 32'hFFE, "R8 zero write");
        wr(OFF_MASK_CLR, 32'h0);
        rd(OFF_MASK_SET, 32'hFFE, "R8 zero clear");
        // R7 clear
        wr(OFF_IRQ_ACK, 32'h001);
        chk(1, 8'h0, 32'h1, "R9 irq holds one cycle");
        chk(1, 8'h0, 32'h0, "R9 irq drops");
        rd(OFF_IRQ_STAT, 32'h0, "R7 clear");
        // R7 clear coinciding with an either-edge event on pin2
        pin_in = 12'h014;
        tick(1);
        wr(OFF_IRQ_ACK, 32'h004);
        rd(OFF_IRQ_STAT, 32'h004, "R7 event wins over clear");
        wr(OFF_IRQ_ACK, 32'h004);
        rd(OFF_IRQ_STAT, 32'h0, "R7 quiet clear");
        // falling edge pin1
        pin_in = 12'h016;
        tick(4);
        rd(OFF_IRQ_STAT, 32'h0, "R5 rising on falling mode");
        pin_in = 12'h014;
        tick(3);
        rd(OFF_IRQ_STAT, 32'h002, "R5 falling sets");
        wr(OFF_IRQ_ACK, 32'h002);
        // R6 level high pin3
        pin_in = 12'h01C;
        tick(3);
        rd(OFF_IRQ_STAT, 32'h008, "R6 level high sets");
        wr(OFF_IRQ_ACK, 32'h008);
        rd(OFF_IRQ_STAT, 32'h008, "R6 level survives clear");
        pin_in = 12'h014;
        tick(3);
        wr(OFF_IRQ_ACK, 32'h008);
        rd(OFF_IRQ_STAT, 32'h0, "R6 clear after level ends");
        // R6 level low pin4
        pin_in = 12'h004;
        tick(3);
        rd(OFF_IRQ_STAT, 32'h010, "R6 level low sets");
        pin_in = 12'h014;
        tick(3);
        wr(OFF_IRQ_ACK, 32'h010);
        rd(OFF_IRQ_STAT, 32'h0, "R6 low clear");
        // either edge, falling direction
        pin_in = 12'h010;
        tick(3);
        rd(OFF_IRQ_STAT, 32'h004, "R5 either edge falling");
        wr(OFF_IRQ_ACK, 32'h004);
        // R4 pin9 through word1
        pin_in = 12'h210;
        tick(3);
        rd(OFF_IRQ_STAT, 32'h200, "R4 pin9 rising");
        rd(OFF_IRQ_VIEW, 32'h0, "R9 pin9 masked");
        // R10 soft reset
        wr(OFF_SOFT_RST, 32'h1);
        rd(OFF_IRQ_EN, 32'h21F, "R10 first step only");
        rd(OFF_SOFT_RST, 32'h1, "R10 reset bit");
        wr(OFF_SOFT_RST, 32'h0);
        rd(OFF_IRQ_EN,   32'h0,   "R10 enable");
        rd(OFF_IRQ_STAT, 32'h0,   "R10 status");
        rd(OFF_MASK_SET, 32'hFFF, "R10 mask");
        rd(OFF_MODE_LO,  32'h0,   "R10 mode");
        rd(OFF_ALT_SEL,  32'h0,   "R10 spare select");
        chk(2, 8'h0, 32'h0,       "R10 oe");
        chk(3, 8'h0, 32'h0,       "R10 out");
        tick(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule